// File: doc/BRIEF.md
# Flash Access Permission Checker

This block decides whether a flash access may proceed. A request names an operation (read, program, page erase or bank erase), a partition (data or info), a bank and a page. The verdict comes back one clock later as a single permit bit. The block also holds all of the protection configuration that feeds this decision, written through a simple one-word-per-cycle configuration port.

Data-partition pages are looked up in eight windows. Each window is a base page plus a page count, and carries its own enable and its own read, program and erase rights. When several enabled windows cover a page, the window with the smallest index decides. A page that no enabled window covers falls back to a default set of rights. Info-partition pages carry individual rights per bank. A bank erase consults only the per-bank erase enable.

Two write-zero-to-clear locks freeze the configuration until reset. The window lock guards the windows, the info page rights and the default rights. The bank lock guards the bank erase enables.

Top module: `flash_perm_chk`

## Requirements
- R1: The verdict is registered. `resp_valid` is high exactly one cycle after a cycle with `req_valid` high and low otherwise, and `resp_ok` is low whenever `resp_valid` is low.
- R2: For a data-partition request (`req_info`=0) with `req_op` 0 (read), 1 (program) or 2 (page erase), an enabled window covers page p when base <= p < base + size. The verdict is then that window's read, program or erase right respectively.
- R3: A window whose enable bit is clear covers no page, whatever its rights, base and size. A window of size 0 covers no page.
- R4: When several enabled windows cover the same page, only the window with the lowest index decides.
- R5: A data page covered by no enabled window takes the matching bit of the default rights.
- R6: For an info-partition request (`req_info`=1, `req_op` 0 to 2) on page p of bank b, the request is permitted only if p < 4, the page entry (b*4+p) is enabled and it grants the requested right. An index of 4 or more is always denied.
- R7: A bank erase (`req_op`=3) is permitted exactly when the erase enable of `req_bank` is set, whatever the partition, page, windows or default rights.
- R8: Configuration writes use `cfg_addr` 0..7 for window k, with `cfg_wdata`[8:0] base, [18:9] size, [19] erase, [20] program, [21] read and [22] enable. Address 8+b*4+p holds info page entry {[3] enable, [2] read, [1] program, [0] erase}. Address 16 holds the default rights {[2] read, [1] program, [0] erase}. Address 17 holds the bank erase enables in bits [1:0]. Address 18 is the window lock and address 19 the bank lock.
- R9: A write to address 18 with `cfg_wdata`[0]=0 clears the window lock (`region_open` goes low); writing 1 has no effect. Once it is cleared, writes to addresses 0..16 are ignored until reset.
- R10: A write to address 19 with `cfg_wdata`[0]=0 clears the bank lock (`bank_open` goes low); writing 1 has no effect. Once it is cleared, writes to address 17 are ignored until reset.
- R11: After reset both locks are open and every right, enable and window field is zero, so every request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| region_open | output | 1 | Window lock state (1 = writable) |
| bank_open | output | 1 | Bank lock state (1 = writable) |
| req_valid | input | 1 | Access request present |
| req_op | input | 2 | 0 read, 1 program, 2 page erase, 3 bank erase |
| req_info | input | 1 | 0 data partition, 1 info partition |
| req_bank | input | 1 | Target bank |
| req_page | input | 9 | Target page index |
| resp_valid | output | 1 | Verdict present |
| resp_ok | output | 1 | Access permitted |

## Verification
Every data page from 0 to 511 is tried in both banks with all four operations, and the info pages 0 to 7 are tried the same way. The configurations include overlapping windows with different rights, which separates lowest-index priority from any other order. They include a disabled window and a zero-size window, which must fall through to the default rights, and a window running past the last page, which exposes a truncated end comparison. Info entries that are disabled but hold rights, together with indices 4 to 7, test the enable gate and the range gate. Sweeps repeated after each lock is cleared show that attempted rewrites leave the verdicts unchanged, while the bank erase enables stay writable until their own lock closes.

// File: rtl/flash_perm_pkg.sv
package flash_perm_pkg;

  parameter int unsigned FP_PAGE_W = 9;
  parameter int unsigned FP_SIZE_W = 10;

  typedef enum logic [1:0] {
    FP_READ   = 2'd0,
    FP_PROG   = 2'd1,
    FP_PERASE = 2'd2,
    FP_BERASE = 2'd3
  } fp_op_e;

  typedef struct packed {
    logic en;
    logic rd;
    logic pg;
    logic er;
  } fp_rights_t;

  typedef struct packed {
    fp_rights_t                r;
    logic [FP_SIZE_W-1:0]      size;
    logic [FP_PAGE_W-1:0]      base;
  } fp_region_t;

  // base <= page < base + size, evaluated one bit wider than the size field
  function automatic logic fp_in_window(logic [FP_PAGE_W-1:0] page,
                                        logic [FP_PAGE_W-1:0] base,
                                        logic [FP_SIZE_W-1:0] size);
    logic [FP_SIZE_W:0] p, lo, hi;
    p  = (FP_SIZE_W+1)'(page);
    lo = (FP_SIZE_W+1)'(base);
    hi = lo + (FP_SIZE_W+1)'(size);
    return (p >= lo) && (p < hi);
  endfunction

  // Right selected by the operation; bank erase is never granted here
  function automatic logic fp_pick(fp_rights_t r, fp_op_e op);
    case (op)
      FP_READ:   return r.rd;
      FP_PROG:   return r.pg;
      FP_PERASE: return r.er;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flash_perm_cfg.sv
module flash_perm_cfg
  import flash_perm_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int NBANK  = 2,
  parameter int NINFO  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output fp_region_t        region_q [NREG],
  output fp_rights_t        info_q   [NBANK*NINFO],
  output fp_rights_t        dflt_q,
  output logic [NBANK-1:0]  berase_q,
  output logic              region_open,
  output logic              bank_open
);

  localparam int NPAGE  = NBANK * NINFO;
  localparam int A_INFO = NREG;
  localparam int A_DFLT = A_INFO + NPAGE;
  localparam int A_BER  = A_DFLT + 1;
  localparam int A_RLK  = A_DFLT + 2;
  localparam int A_BLK  = A_DFLT + 3;
  localparam int RW     = $bits(fp_region_t);

  logic guarded_wr;
  logic bank_wr;
  assign guarded_wr = we && region_open;
  assign bank_wr    = we && bank_open;

  for (genvar g = 0; g < NREG; g++) begin : g_region
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) region_q[g] <= '0;
      else if (guarded_wr && addr == ADDR_W'(g)) region_q[g] <= fp_region_t'(wdata[RW-1:0]);
    end
  end

  for (genvar g = 0; g < NPAGE; g++) begin : g_info
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) info_q[g] <= '0;
      else if (guarded_wr && addr == ADDR_W'(A_INFO + g)) info_q[g] <= fp_rights_t'(wdata[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dflt_q <= '0;
    else if (guarded_wr && addr == ADDR_W'(A_DFLT)) dflt_q <= fp_rights_t'({1'b0, wdata[2:0]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) berase_q <= '0;
    else if (bank_wr && addr == ADDR_W'(A_BER)) berase_q <= wdata[NBANK-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_open <= 1'b1;
      bank_open   <= 1'b1;
    end else if (we && !wdata[0]) begin
      if (addr == ADDR_W'(A_RLK)) region_open <= 1'b0;
      if (addr == ADDR_W'(A_BLK)) bank_open   <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_perm_match.sv
module flash_perm_match
  import flash_perm_pkg::*;
#(
  parameter int NREG = 8
) (
  input  fp_region_t           regions [NREG],
  input  logic [FP_PAGE_W-1:0] page,
  output logic                 hit,
  output fp_rights_t           rights,
  output logic [NREG-1:0]      in_win
);

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign in_win[g] = regions[g].r.en &&
                       fp_in_window(page, regions[g].base, regions[g].size);
  end

  // walk from the highest index down so the lowest covering window is kept
  always_comb begin
    hit    = |in_win;
    rights = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (in_win[i]) rights = regions[i].r;
    end
  end

endmodule

// File: rtl/flash_perm_info.sv
module flash_perm_info
  import flash_perm_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int NINFO  = 4,
  parameter int BANK_W = 1
) (
  input  fp_rights_t           pages [NBANK*NINFO],
  input  logic [BANK_W-1:0]    bank,
  input  logic [FP_PAGE_W-1:0] page,
  input  fp_op_e               op,
  output logic                 ok
);

  localparam int NPAGE = NBANK * NINFO;

  logic       in_range;
  int         idx;
  fp_rights_t sel;

  always_comb begin
    in_range = (int'(page) < NINFO) && (int'(bank) < NBANK);
    idx      = in_range ? (int'(bank) * NINFO + int'(page)) : 0;
    if (idx >= NPAGE) idx = 0;
    sel      = pages[idx];
    ok       = in_range && sel.en && fp_pick(sel, op);
  end

endmodule

// File: rtl/flash_perm_chk.sv
module flash_perm_chk
  import flash_perm_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NBANK = 2,
  parameter int NINFO = 4,
  localparam int ADDR_W = $clog2(NREG + NBANK * NINFO + 4),
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic                 region_open,
  output logic                 bank_open,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic                 req_info,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [FP_PAGE_W-1:0] req_page,
  output logic                 resp_valid,
  output logic                 resp_ok
);

  localparam int NPAGE = NBANK * NINFO;

  fp_region_t       region_q [NREG];
  fp_rights_t       info_q   [NPAGE];
  fp_rights_t       dflt_rights;
  logic [NBANK-1:0] berase_en;

  flash_perm_cfg #(
    .NREG(NREG), .NBANK(NBANK), .NINFO(NINFO), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .region_q(region_q), .info_q(info_q), .dflt_q(dflt_rights),
    .berase_q(berase_en), .region_open(region_open), .bank_open(bank_open)
  );

  fp_op_e op;
  assign op = fp_op_e'(req_op);

  logic            win_hit;
  fp_rights_t      win_rights;
  logic [NREG-1:0] win_vec;

  flash_perm_match #(.NREG(NREG)) u_match (
    .regions(region_q), .page(req_page),
    .hit(win_hit), .rights(win_rights), .in_win(win_vec)
  );

  logic info_ok;
  flash_perm_info #(.NBANK(NBANK), .NINFO(NINFO), .BANK_W(BANK_W)) u_info (
    .pages(info_q), .bank(req_bank), .page(req_page), .op(op), .ok(info_ok)
  );

  logic data_ok, berase_ok, decide;
  always_comb begin
    data_ok   = win_hit ? fp_pick(win_rights, op) : fp_pick(dflt_rights, op);
    berase_ok = (int'(req_bank) < NBANK) && berase_en[req_bank];
    if (op == FP_BERASE) decide = berase_ok;
    else if (req_info)   decide = info_ok;
    else                 decide = data_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= req_valid && decide;
    end
  end

endmodule

// File: rtl/flash_perm_chk_sva.sv
module flash_perm_chk_sva #(
  parameter int NBANK  = 2,
  parameter int NINFO  = 4,
  parameter int BANK_W = 1,
  parameter int PAGE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              req_info,
  input logic [BANK_W-1:0] req_bank,
  input logic [PAGE_W-1:0] req_page,
  input logic              resp_valid,
  input logic              resp_ok,
  input logic              region_open,
  input logic              bank_open,
  input logic [3:0]        dflt_rights,
  input logic [NBANK-1:0]  berase_en
);

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  a_r1_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  a_r1_ok_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !resp_ok);

  a_r7_bank_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> (resp_ok == $past(berase_en[req_bank])));

  a_r6_info_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_info && req_op != 2'd3 && int'(req_page) >= NINFO) |=> !resp_ok);

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !region_open |=> !region_open);

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |=> !bank_open);

  a_r9_default_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !region_open |=> $stable(dflt_rights));

  a_r10_erase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |=> $stable(berase_en));

endmodule

bind flash_perm_chk flash_perm_chk_sva #(
  .NBANK(NBANK), .NINFO(NINFO), .BANK_W(BANK_W), .PAGE_W(flash_perm_pkg::FP_PAGE_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_info(req_info), .req_bank(req_bank), .req_page(req_page),
  .resp_valid(resp_valid), .resp_ok(resp_ok), .region_open(region_open),
  .bank_open(bank_open), .dflt_rights(dflt_rights), .berase_en(berase_en)
);

// File: tb/flash_perm_chk_test.sv
module flash_perm_chk_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        region_open, bank_open;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic        req_info = 1'b0;
  logic        req_bank = 1'b0;
  logic [8:0]  req_page = '0;
  logic        resp_valid, resp_ok;

  always #10 clk = ~clk;

  flash_perm_chk uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .region_open(region_open), .bank_open(bank_open),
    .req_valid(req_valid), .req_op(req_op), .req_info(req_info),
    .req_bank(req_bank), .req_page(req_page), .resp_valid(resp_valid),
    .resp_ok(resp_ok)
  );

  int checks = 0;
  int fails  = 0;

  // bench-side model of the configuration
  int       m_base [8];
  int       m_size [8];
  bit [3:0] m_rt   [8];   // {en, rd, pg, er}
  bit [3:0] m_info [8];   // {en, rd, pg, er}
  bit [2:0] m_dflt;       // {rd, pg, er}
  bit [1:0] m_ber;
  bit       m_ropen = 1'b1;
  bit       m_bopen = 1'b1;

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkreg(bit en, bit rd, bit pg, bit er, int base, int size);
    logic [31:0] w;
    w = '0;
    w[8:0]   = base[8:0];
    w[18:9]  = size[9:0];
    w[19]    = er;
    w[20]    = pg;
    w[21]    = rd;
    w[22]    = en;
    return w;
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[4:0]; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 8) begin
      if (m_ropen) begin
        m_base[addr] = int'(data[8:0]);
        m_size[addr] = int'(data[18:9]);
        m_rt[addr]   = {data[22], data[21], data[20], data[19]};
      end
    end else if (addr < 16) begin
      if (m_ropen) m_info[addr-8] = data[3:0];
    end else if (addr == 16) begin
      if (m_ropen) m_dflt = data[2:0];
    end else if (addr == 17) begin
      if (m_bopen) m_ber = data[1:0];
    end else if (addr == 18) begin
      if (!data[0]) m_ropen = 1'b0;
    end else if (addr == 19) begin
      if (!data[0]) m_bopen = 1'b0;
    end
  endtask

  function automatic bit sel3(bit [2:0] r, int op);
    if (op == 0) return r[2];
    if (op == 1) return r[1];
    if (op == 2) return r[0];
    return 1'b0;
  endfunction

  function automatic bit exp_ok(int op, bit info, int bank, int page);
    if (op == 3) return m_ber[bank];
    if (info) begin
      if (page >= 4) return 1'b0;
      if (!m_info[bank*4+page][3]) return 1'b0;
      return sel3(m_info[bank*4+page][2:0], op);
    end
    for (int i = 0; i < 8; i++) begin
      if (m_rt[i][3] && page >= m_base[i] && page < m_base[i] + m_size[i])
        return sel3(m_rt[i][2:0], op);
    end
    return sel3(m_dflt, op);
  endfunction

  task automatic probe(int op, bit info, int bank, int page);
    bit    e;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_info = info;
    req_bank = bank[0]; req_page = page[8:0];
    e = exp_ok(op, info, bank, page);
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 3)   tag = $sformatf("R7 bank=%0d page=%0d", bank, page);
    else if (info) tag = $sformatf("R6 op=%0d bank=%0d page=%0d", op, bank, page);
    else           tag = $sformatf("R2/R3/R4/R5/R8 op=%0d bank=%0d page=%0d", op, bank, page);
    check({30'd0, resp_valid, resp_ok}, {30'd0, 1'b1, e}, tag);
  endtask

  task automatic sweep();
    for (int page = 0; page < 512; page++)
      for (int op = 0; op < 4; op++)
        for (int bank = 0; bank < 2; bank++)
          probe(op, 1'b0, bank, page);
    for (int page = 0; page < 8; page++)
      for (int op = 0; op < 4; op++)
        for (int bank = 0; bank < 2; bank++)
          probe(op, 1'b1, bank, page);
    // idle cycle after the last probe: verdict must be withdrawn
    @(negedge clk);
    check({30'd0, resp_valid, resp_ok}, 32'd0, "R1 idle after request");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_rt[i] = '0; m_info[i] = '0;
    end
    m_dflt = '0; m_ber = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check({31'd0, region_open}, 32'd1, "R11 region_open after reset");
    check({31'd0, bank_open},   32'd1, "R11 bank_open after reset");
    check({30'd0, resp_valid, resp_ok}, 32'd0, "R1 R11 no verdict without request");
    sweep();

    // configuration A: overlaps, disabled, zero-size, end-of-range windows
    wr(0, mkreg(1, 1, 0, 0, 10, 5));     // pages 10..14 read only
    wr(1, mkreg(1, 1, 1, 1, 12, 20));    // pages 12..31 all rights
    wr(2, mkreg(0, 1, 1, 1, 40, 10));    // disabled
    wr(3, mkreg(1, 0, 1, 1, 500, 20));   // 500..511, runs past the end
    wr(4, mkreg(1, 1, 1, 1, 100, 0));    // empty
    wr(6, mkreg(1, 0, 0, 0, 13, 1));     // shadowed by window 0
    wr(7, mkreg(1, 0, 0, 1, 0, 1));      // page 0 erase only
    wr(16, 32'h4);                       // default: read
    wr(8,  32'hC);                       // bank0 page0: en rd
    wr(9,  32'hB);                       // bank0 page1: en pg er
    wr(10, 32'h7);                       // bank0 page2: rights but disabled
    wr(15, 32'hF);                       // bank1 page3: all
    wr(17, 32'h2);                       // bank1 erase enabled
    sweep();

    // R9: writing 1 to the lock leaves it open
    wr(18, 32'h1);
    check({31'd0, region_open}, 32'd1, "R9 lock write of 1 ignored");
    wr(19, 32'h1);
    check({31'd0, bank_open}, 32'd1, "R10 lock write of 1 ignored");

    // configuration B
    wr(1, mkreg(1, 1, 0, 0, 12, 20));
    wr(5, mkreg(1, 0, 1, 0, 200, 56));
    wr(16, 32'h3);                       // default: program and erase
    wr(12, 32'hA);                       // bank1 page0: en pg
    sweep();

    // R9: clear window lock, rewrites must be ignored
    wr(18, 32'h0);
    check({31'd0, region_open}, 32'd0, "R9 window lock cleared");
    check({31'd0, bank_open},   32'd1, "R10 bank lock independent");
    wr(0, mkreg(1, 1, 1, 1, 0, 511));
    wr(16, 32'h7);
    wr(8, 32'h0);
    wr(13, 32'hF);
    wr(17, 32'h1);                       // still allowed: bank lock open
    wr(18, 32'h1);
    check({31'd0, region_open}, 32'd0, "R9 lock stays closed");
    sweep();

    // R10: clear bank lock, erase enables frozen
    wr(19, 32'h0);
    check({31'd0, bank_open}, 32'd0, "R10 bank lock cleared");
    wr(17, 32'h2);
    wr(19, 32'h1);
    check({31'd0, bank_open}, 32'd0, "R10 lock stays closed");
    for (int bank = 0; bank < 2; bank++)
      for (int page = 0; page < 4; page++) begin
        probe(3, 1'b0, bank, page * 100);
        probe(3, 1'b1, bank, page);
      end

    summary();
    $finish;
  end

endmodule